// File: doc/BRIEF.md
# Serial EEPROM Slave

This block is a two-wire serial slave that looks to the bus like a small serial EEPROM. It watches a synchronised copy of the clock and data lines and finds start and stop conditions. It answers one 7-bit device address, made of a fixed type code and three strap inputs. After a write-addressed start it takes a word pointer. It then either collects data bytes for a page write, or, after a repeated start, returns array contents for a sequential read. The data line is driven open-drain: the block only ever pulls it low.

Written bytes go into a page buffer first. They reach the storage array only when a self-timed write cycle finishes. That cycle begins at the stop that ends a transfer carrying at least one data byte. While the cycle runs, the slave ignores the bus. A master therefore finds out that the write is done by polling: it repeats an address-only transfer until the address is acknowledged.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The device answers the 7-bit address {4'b1010, dev_sel[2:0]}. With dev_sel = 3'b101 the write byte is 0xAA and the read byte is 0xAB (bit 0 is R/W, 1 = read). A matching address is acknowledged by holding SDA low through the ninth clock. Any other address gets no acknowledge.
- R2: With the default 256-byte array, the first byte after a write-addressed start loads a one-byte word pointer, and that byte is acknowledged. Arrays larger than 256 bytes take a high byte and then a low byte.
- R3: Every write data byte is acknowledged and goes to the page buffer at the pointer. Buffered bytes reach the array only when the write cycle completes.
- R4: During a write the pointer increments inside the current PAGE_BYTES page (16 bytes by default). A byte written past the page end lands at the page start, and the last byte written to a location wins.
- R5: A read returns bytes MSB first, starting at the pointer. The pointer increments after each byte and wraps from the array end to address 0. Reading carries on while the master acknowledges. After the master's not-acknowledge the slave stops driving SDA.
- R6: A random read is a write-addressed transfer that sets the pointer, then a repeated start, then a read-addressed transfer.
- R7: A stop after at least one buffered data byte starts a busy period of BUSY_CYCLES clock cycles. During that period no address is acknowledged and SDA is never pulled low.
- R8: A transfer that ends without data, such as an address-only poll, starts no busy period. The next address is acknowledged at once.
- R9: A start or stop at any point abandons the current byte and returns to address matching. A partial data byte is dropped, and a start discards bytes still held in the page buffer.
- R10: After reset SDA is released and every array location reads 0x00.
- R11: The slave changes the level it drives on SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the wired bus |
| dev_sel | input | 3 | Strap inputs forming the low three device address bits |
| sda_low | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
The addressing path is tried with both a matching and a non-matching device byte, which separates a correct address compare from a slave that acknowledges everything. Writes are tried in three shapes: a single byte, a page write that crosses the page end, and a page write longer than a page. Reading these back with sequential reads tells in-page wrap apart from a plain increment, and shows whether the last write to a location wins. A read starting near the top of the array checks the wrap at the array end. The master's not-acknowledge is then checked by confirming that the slave stops driving. Polls sent straight after a write, straight after an address-only transfer, and straight after an aborted partial byte show when the busy period starts and when it does not.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    // Fixed device-type nibble sent ahead of the three strap bits
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_PTRHI,
        ST_PTRLO,
        ST_WRITE,
        ST_READ
    } xfer_mode_e;

    typedef enum logic {
        PH_BITS,
        PH_ACK
    } byte_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl_level;
        logic sda_level;
    } bus_evt_t;

    function automatic logic dev_match(input logic [7:0] byte_v, input logic [2:0] strap);
        return byte_v[7:1] == {DEV_TYPE, strap};
    endfunction

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync
    import eeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t ev
);
    logic [1:0] scl_meta, sda_meta;
    logic       scl_prev, sda_prev;
    logic       scl_s, sda_s;

    assign scl_s = scl_meta[1];
    assign sda_s = sda_meta[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_meta <= 2'b11;
            sda_meta <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_meta <= {scl_meta[0], scl_in};
            sda_meta <= {sda_meta[0], sda_in};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        ev.scl_level = scl_s;
        ev.sda_level = sda_s;
        ev.scl_rise  = scl_s & ~scl_prev;
        ev.scl_fall  = ~scl_s & scl_prev;
        ev.start     = scl_s & scl_prev & sda_prev & ~sda_s;
        ev.stop      = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (go && !busy) begin
            busy   <= 1'b1;
            remain <= CW'(BUSY_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // R7
    go_starts_busy_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

endmodule

// File: rtl/ee_word_store.sv
module ee_word_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear_buf,
    input  logic                         buf_we,
    input  logic [$clog2(MEM_BYTES)-1:0] buf_addr,
    input  logic [7:0]                   buf_data,
    input  logic                         commit,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         pending
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PB = $clog2(PAGE_BYTES);

    logic [7:0]            mem      [MEM_BYTES];
    logic [7:0]            page_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [AW-PB-1:0]      page_sel;

    assign rd_data = mem[rd_addr];
    assign pending = |valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++)  mem[i] <= 8'h00;
            for (int j = 0; j < PAGE_BYTES; j++) page_buf[j] <= 8'h00;
            valid    <= '0;
            page_sel <= '0;
        end else begin
            if (commit) begin
                for (int j = 0; j < PAGE_BYTES; j++)
                    if (valid[j]) mem[{page_sel, PB'(j)}] <= page_buf[j];
                valid <= '0;
            end else if (clear_buf) begin
                valid <= '0;
            end
            if (buf_we) begin
                page_buf[buf_addr[PB-1:0]] <= buf_data;
                valid[buf_addr[PB-1:0]]    <= 1'b1;
                page_sel                   <= buf_addr[AW-1:PB];
            end
        end
    end

    // R3
    commit_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> pending);

endmodule

// File: rtl/ee_protocol_fsm.sv
module ee_protocol_fsm
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  bus_evt_t                     ev,
    input  logic                         busy,
    input  logic [2:0]                   dev_sel,
    input  logic [7:0]                   rd_data,
    input  logic                         pending,
    output logic                         sda_low,
    output logic [$clog2(MEM_BYTES)-1:0] ptr,
    output logic                         buf_we,
    output logic [7:0]                   shreg,
    output logic                         clear_buf,
    output logic                         write_go
);
    localparam int  AW       = $clog2(MEM_BYTES);
    localparam int  PB       = $clog2(PAGE_BYTES);
    localparam bit  TWO_BYTE = (AW > 8);

    xfer_mode_e  mode;
    byte_phase_e phase;
    logic [3:0]  bitcnt;
    logic        rw;
    logic        mack;
    logic [AW-1:0] ptr_after_hi, ptr_after_lo, ptr_page_next;

    generate
        if (TWO_BYTE) begin : g_ptr2
            assign ptr_after_hi = {shreg[AW-9:0], ptr[7:0]};
            assign ptr_after_lo = {ptr[AW-1:8], shreg};
        end else begin : g_ptr1
            assign ptr_after_hi = ptr;
            assign ptr_after_lo = shreg[AW-1:0];
        end
    endgenerate

    assign ptr_page_next = {ptr[AW-1:PB], ptr[PB-1:0] + PB'(1)};

    assign clear_buf = ev.start && !busy;
    assign write_go  = ev.stop && !busy && pending;
    assign buf_we    = !busy && !ev.start && !ev.stop && mode == ST_WRITE &&
                       phase == PH_BITS && ev.scl_fall && bitcnt == 4'd8;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= ST_IDLE;
            phase   <= PH_BITS;
            bitcnt  <= '0;
            shreg   <= '0;
            sda_low <= 1'b0;
            ptr     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
        end else if (busy) begin
            mode    <= ST_IDLE;
            phase   <= PH_BITS;
            sda_low <= 1'b0;
        end else if (ev.start) begin
            mode    <= ST_DEVADDR;
            phase   <= PH_BITS;
            bitcnt  <= '0;
            sda_low <= 1'b0;
        end else if (ev.stop) begin
            mode    <= ST_IDLE;
            phase   <= PH_BITS;
            sda_low <= 1'b0;
        end else if (mode == ST_READ) begin
            if (phase == PH_BITS) begin
                if (ev.scl_fall) begin
                    if (bitcnt == 4'd7) begin
                        sda_low <= 1'b0;
                        phase   <= PH_ACK;
                        bitcnt  <= '0;
                        ptr     <= ptr + 1'b1;
                    end else begin
                        shreg   <= {shreg[6:0], 1'b0};
                        sda_low <= ~shreg[6];
                        bitcnt  <= bitcnt + 1'b1;
                    end
                end
            end else begin
                if (ev.scl_rise) mack <= ~ev.sda_level;
                if (ev.scl_fall) begin
                    if (mack) begin
                        shreg   <= rd_data;
                        sda_low <= ~rd_data[7];
                        phase   <= PH_BITS;
                    end else begin
                        mode    <= ST_IDLE;
                    end
                end
            end
        end else if (mode != ST_IDLE) begin
            if (phase == PH_BITS) begin
                if (ev.scl_rise && bitcnt != 4'd8) begin
                    shreg  <= {shreg[6:0], ev.sda_level};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (ev.scl_fall && bitcnt == 4'd8) begin
                    unique case (mode)
                        ST_DEVADDR: begin
                            if (dev_match(shreg, dev_sel)) begin
                                rw      <= shreg[0];
                                sda_low <= 1'b1;
                                phase   <= PH_ACK;
                            end else begin
                                mode    <= ST_IDLE;
                            end
                        end
                        ST_PTRHI: begin
                            ptr     <= ptr_after_hi;
                            sda_low <= 1'b1;
                            phase   <= PH_ACK;
                        end
                        ST_PTRLO: begin
                            ptr     <= ptr_after_lo;
                            sda_low <= 1'b1;
                            phase   <= PH_ACK;
                        end
                        ST_WRITE: begin
                            ptr     <= ptr_page_next;
                            sda_low <= 1'b1;
                            phase   <= PH_ACK;
                        end
                        default: mode <= ST_IDLE;
                    endcase
                end
            end else if (ev.scl_fall) begin
                sda_low <= 1'b0;
                phase   <= PH_BITS;
                bitcnt  <= '0;
                unique case (mode)
                    ST_DEVADDR: begin
                        if (rw) begin
                            mode    <= ST_READ;
                            shreg   <= rd_data;
                            sda_low <= ~rd_data[7];
                        end else begin
                            mode    <= TWO_BYTE ? ST_PTRHI : ST_PTRLO;
                        end
                    end
                    ST_PTRHI: mode <= ST_PTRLO;
                    default:  mode <= ST_WRITE;
                endcase
            end
        end
    end

    // R7
    busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_low);

    // R11
    drive_in_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !$past(ev.scl_level));

    // R4
    page_locked_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> ptr[AW-1:PB] == $past(ptr[AW-1:PB]));

    // R9
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_low);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES   = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    output logic       sda_low
);
    localparam int AW = $clog2(MEM_BYTES);

    bus_evt_t      ev;
    logic          busy, done;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data, shreg;
    logic          pending, buf_we, clear_buf, write_go;

    ee_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    ee_write_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (write_go),
        .busy (busy),
        .done (done)
    );

    ee_word_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear_buf (clear_buf),
        .buf_we    (buf_we),
        .buf_addr  (ptr),
        .buf_data  (shreg),
        .commit    (done),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .pending   (pending)
    );

    ee_protocol_fsm #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .dev_sel   (dev_sel),
        .rd_data   (rd_data),
        .pending   (pending),
        .sda_low   (sda_low),
        .ptr       (ptr),
        .buf_we    (buf_we),
        .shreg     (shreg),
        .clear_buf (clear_buf),
        .write_go  (write_go)
    );

endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
    localparam int MEM_BYTES   = 256;
    localparam int PAGE_BYTES  = 16;
    localparam int BUSY_CYCLES = 600;
    localparam int Q           = 24;
    localparam logic [7:0] WR_BYTE = 8'hAA;
    localparam logic [7:0] RD_BYTE = 8'hAB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_low;
    logic sda_line;
    logic [2:0] dev_sel = 3'b101;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [7:0] model [MEM_BYTES];

    assign sda_line = m_sda & ~sda_low;

    always #2 clk = ~clk;

    serial_eeprom_slave #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_serial_eeprom_slave (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (m_scl),
        .sda_in  (sda_line),
        .dev_sel (dev_sel),
        .sda_low (sda_low)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; b = sda_line; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~give_ack);
    endtask

    task automatic poll(output logic ack);
        bus_start();
        send_byte(WR_BYTE, ack);
        bus_stop();
    endtask

    task automatic wait_cycle();
        repeat (BUSY_CYCLES + 100) @(negedge clk);
    endtask

    // Page write starting at p; byte i carries first + i; the model applies the in-page wrap.
    task automatic write_seq(input logic [7:0] p, input int n, input logic [7:0] first);
        logic ack;
        bus_start();
        send_byte(WR_BYTE, ack); check("R1", "write address ack", ack, 1'b1);
        send_byte(p, ack);       check("R2", "pointer ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(first + 8'(i), ack);
            check("R3", "data ack", ack, 1'b1);
        end
        bus_stop();
        poll(ack);
        check("R7", "poll during write cycle", ack, 1'b0);
        wait_cycle();
        for (int i = 0; i < n; i++)
            model[{p[7:4], 4'(p[3:0] + 4'(i))}] = first + 8'(i);
    endtask

    task automatic read_seq(input logic [7:0] p, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(WR_BYTE, ack); check("R6", "set-pointer address ack", ack, 1'b1);
        send_byte(p, ack);       check("R6", "set-pointer ack", ack, 1'b1);
        bus_start();
        send_byte(RD_BYTE, ack); check("R6", "read address ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check(req, $sformatf("read byte at %0h", 8'(p + 8'(i))), d, model[8'(p + 8'(i))]);
        end
        check("R5", "SDA released after master NACK", sda_low, 1'b0);
        bus_stop();
    endtask

    task automatic t_address();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack);
        check("R1", "foreign address 0x50 no ack", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hB4, ack);
        check("R1", "foreign address 0x5A no ack", ack, 1'b0);
        bus_stop();
        poll(ack);
        check("R1", "own address ack", ack, 1'b1);
    endtask

    task automatic t_byte_write();
        logic ack;
        write_seq(8'h10, 1, 8'h3C);
        poll(ack);
        check("R7", "ack after write cycle", ack, 1'b1);
        poll(ack);
        check("R8", "address-only poll starts no cycle", ack, 1'b1);
        read_seq(8'h10, 1, "R3");
        read_seq(8'h80, 1, "R10");
    endtask

    task automatic t_page_wrap();
        write_seq(8'h2E, 5, 8'hA0);
        read_seq(8'h20, 3, "R4");
        read_seq(8'h2E, 3, "R4");
        write_seq(8'h40, 18, 8'h80);
        read_seq(8'h40, 16, "R4");
    endtask

    task automatic t_read_wrap();
        write_seq(8'hFE, 2, 8'h11);
        read_seq(8'hFE, 3, "R5");
    endtask

    task automatic t_abort();
        logic ack;
        bus_start();
        send_byte(WR_BYTE, ack); check("R9", "address ack", ack, 1'b1);
        send_byte(8'h60, ack);   check("R9", "pointer ack", ack, 1'b1);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_start();
        send_byte(WR_BYTE, ack); check("R9", "ack after mid-byte start", ack, 1'b1);
        bus_stop();
        poll(ack);
        check("R9", "partial byte starts no cycle", ack, 1'b1);
        read_seq(8'h60, 1, "R9");
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'h00;
        repeat (8) @(negedge clk);
        check("R10", "SDA released in reset", sda_low, 1'b0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R10", "SDA released after reset", sda_low, 1'b0);
        t_address();
        t_byte_write();
        t_page_wrap();
        t_read_wrap();
        t_abort();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (R1..): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule